// File: doc/BRIEF.md
# Remote Device Configuration Access Controller

This block sits on the host side of a multi-drop serial link to peripheral devices. It holds one 32-bit control word through which software starts configuration accesses to remote devices. Software selects one of four target devices, an access kind and a 12-bit register address, then writes the start bit. The sequencer sends a single request to a link engine outside this block and waits for that engine's completion pulse. It then stores a 3-bit completion code and keeps any returned data on a separate read-data output. Software acknowledges the result by writing ones to the code field before it starts the next access.

A protection bit guards the standard configuration space at addresses below 0x800. Software can set this bit but cannot clear it; only the block reset clears it. While the bit is set, a configuration write into the protected range is never sent to the link. The sequencer finishes it locally with code 3 instead. An external fatal-link-error input suspends the protection for as long as it is high, so that a recovery agent can reconfigure a broken link.

The sequencer has four states. IDLE waits for the start bit. ISSUE holds the request valid until the engine accepts it. WAIT waits for the completion pulse. REJECT is the single cycle in which a locked write is retired. The transitions are: start-accepted (IDLE to ISSUE), start-locked (IDLE to REJECT), request-taken (ISSUE to WAIT), engine-done (WAIT to IDLE) and reject-retire (REJECT to IDLE).

Top module: `remote_cfg_access`

## Requirements
- R1: After reset the control word reads 0x00000000 and the read data is 0. The request valid is low and every chip select (active low, one per device) is high.
- R2: Control word layout: bit 31 start, bits 30:28 code, bit 27 lock, bits 20:19 target, bits 17:16 kind (00 config read, 01 config write, 10 status read, 11 in-band reset), bits 11:0 address. Bits 26:21, 18 and 15:12 read as zero and ignore writes.
- R3: An accepted start raises the request valid one cycle after the write edge. The request carries kind, target and address, and the chip select of the target is driven low. All of these hold steady until the engine asserts ready.
- R4: On the cycle of the engine's completion pulse the start bit clears and the code field takes the returned code. For a config read, the read data takes the returned 32-bit value.
- R5: A start is accepted only while the code field is zero. Writing ones to code bits clears those bits.
- R6: Status read and in-band reset send address 0. A status read keeps only the low 16 bits of the returned data, with the upper bits zero. An in-band reset, like a config write, sets the read data to 0.
- R7: The lock bit sets when a 1 is written to it, does not clear when a 0 is written, and clears only on reset.
- R8: While the lock is set and the fatal flag is low, a config write to an address below 0x800 issues no request. The start bit clears and the code becomes 3 two cycles after the write edge.
- R9: The lock does not affect config writes at 0x800 and above, or reads.
- R10: While the fatal-link-error input is high, a locked config write below 0x800 is issued normally.
- R11: While an access is in flight, writes to the target, kind, address and code fields have no effect.
- R12: A completion pulse that arrives while no access is waiting changes neither the code nor the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low platform reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word readback |
| acc_rdata | output | 32 | Data returned by the last completed access |
| link_fatal_err | input | 1 | Fatal link error flag, suspends the lock |
| req_valid | output | 1 | Request to the link engine |
| req_ready | input | 1 | Link engine accepts the request |
| req_kind | output | 2 | Access kind of the request |
| req_target | output | 2 | Target device of the request |
| req_addr | output | 12 | Register address (0 for status read and in-band reset) |
| req_cs_n | output | 4 | Active-low chip select per device, valid with the request |
| done_valid | input | 1 | Single-cycle completion pulse from the engine |
| done_code | input | 3 | Completion code |
| done_data | input | 32 | Returned data |

## Verification
If the sequencer sits in the wrong state, the ports show it within one or two cycles. A request appears where the start bit was refused, a locked write reaches the link, or the start bit stays set after the completion pulse. A bad field register shows up at once in the readback of the control word, or in a request payload or chip select that changes while the engine is stalled. A wrong data mask or lock path shows in the read data or code field on the cycle after completion. The directed scenarios sample each of these points on the exact cycle it should change.

// File: rtl/cfgacc_pkg.sv
package cfgacc_pkg;

    typedef enum logic [1:0] {
        KIND_CFG_RD  = 2'b00,
        KIND_CFG_WR  = 2'b01,
        KIND_STAT_RD = 2'b10,
        KIND_INB_RST = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_REJECT
    } seq_state_e;

    localparam logic [2:0] CODE_CLEAR = 3'd0;
    localparam logic [2:0] CODE_FATAL = 3'd3;

endpackage

// File: rtl/cfgacc_regs.sv
module cfgacc_regs
    import cfgacc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int TGT_W  = 2,
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_go,
    input  logic [2:0]        wr_code_clr,
    input  logic              wr_lock,
    input  logic [TGT_W-1:0]  wr_target,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              fin,
    input  logic [2:0]        fin_code,
    input  logic [DATA_W-1:0] fin_data,
    output logic              go,
    output logic [2:0]        code,
    output logic              lock,
    output logic [TGT_W-1:0]  target,
    output acc_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);

    localparam int HI_W = DATA_W - STAT_W;

    logic [DATA_W-1:0] kept_data;

    always_comb begin
        unique case (kind)
            KIND_CFG_RD:  kept_data = fin_data;
            KIND_STAT_RD: kept_data = {{HI_W{1'b0}}, fin_data[STAT_W-1:0]};
            default:      kept_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go     <= 1'b0;
            code   <= CODE_CLEAR;
            lock   <= 1'b0;
            target <= '0;
            kind   <= KIND_CFG_RD;
            addr   <= '0;
            rdata  <= '0;
        end else begin
            if (wr_en && wr_lock)
                lock <= 1'b1;
            if (fin) begin
                go    <= 1'b0;
                code  <= fin_code;
                rdata <= kept_data;
            end else if (wr_en && !go) begin
                target <= wr_target;
                kind   <= acc_kind_e'(wr_kind);
                addr   <= wr_addr;
                code   <= code & ~wr_code_clr;
                if (wr_go && code == CODE_CLEAR)
                    go <= 1'b1;
            end
        end
    end

    // R5
    go_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> code == CODE_CLEAR);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go && !fin |=> $stable(target) && $stable(kind) && $stable(addr));

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    // R4
    fin_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> go);

endmodule

// File: rtl/cfgacc_seq.sv
module cfgacc_seq
    import cfgacc_pkg::*;
#(
    parameter int                DATA_W     = 32,
    parameter int                ADDR_W     = 12,
    parameter int                TGT_W      = 2,
    parameter logic [ADDR_W-1:0] PROT_LIMIT = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  acc_kind_e         kind,
    input  logic [TGT_W-1:0]  target,
    input  logic [ADDR_W-1:0] addr,
    input  logic              lock_eff,
    input  logic              req_ready,
    input  logic              done_valid,
    input  logic [2:0]        done_code,
    input  logic [DATA_W-1:0] done_data,
    output logic              req_valid,
    output acc_kind_e         req_kind,
    output logic [TGT_W-1:0]  req_target,
    output logic [ADDR_W-1:0] req_addr,
    output logic              fin,
    output logic [2:0]        fin_code,
    output logic [DATA_W-1:0] fin_data
);

    seq_state_e state, nxt;
    logic       blocked;
    logic       uses_addr;

    assign blocked   = (kind == KIND_CFG_WR) && (addr < PROT_LIMIT) && lock_eff;
    assign uses_addr = (kind == KIND_CFG_RD) || (kind == KIND_CFG_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (go) nxt = blocked ? S_REJECT : S_ISSUE;
            S_ISSUE:  if (req_ready) nxt = S_WAIT;
            S_WAIT:   if (done_valid) nxt = S_IDLE;
            S_REJECT: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        req_valid  = 1'b0;
        fin        = 1'b0;
        fin_code   = done_code;
        fin_data   = done_data;
        req_kind   = kind;
        req_target = target;
        req_addr   = uses_addr ? addr : '0;
        unique case (state)
            S_IDLE:   ;
            S_ISSUE:  req_valid = 1'b1;
            S_WAIT:   fin = done_valid;
            S_REJECT: begin
                fin      = 1'b1;
                fin_code = CODE_FATAL;
            end
            default:  ;
        endcase
    end

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)
            && $stable(req_kind) && $stable(req_target));

    // R8
    no_locked_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) && req_kind == KIND_CFG_WR && req_addr < PROT_LIMIT
            |-> !$past(lock_eff));

endmodule

// File: rtl/remote_cfg_access.sv
module remote_cfg_access
    import cfgacc_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 12,
    parameter int          NDEV       = 4,
    parameter int          STAT_W     = 16,
    parameter logic [11:0] PROT_LIMIT = 12'h800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              link_fatal_err,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_kind,
    output logic [1:0]        req_target,
    output logic [ADDR_W-1:0] req_addr,
    output logic [NDEV-1:0]   req_cs_n,
    input  logic              done_valid,
    input  logic [2:0]        done_code,
    input  logic [DATA_W-1:0] done_data
);

    localparam int TGT_W = 2;

    logic              go, lock, fin, lock_eff;
    logic [2:0]        code, fin_code;
    logic [TGT_W-1:0]  target;
    acc_kind_e         kind, rq_kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] fin_data;
    logic              unused_rsvd;

    assign unused_rsvd = ^{reg_wdata[26:21], reg_wdata[18], reg_wdata[15:12]};
    assign lock_eff    = lock && !link_fatal_err;

    cfgacc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W), .STAT_W(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en),
        .wr_go(reg_wdata[31]), .wr_code_clr(reg_wdata[30:28]), .wr_lock(reg_wdata[27]),
        .wr_target(reg_wdata[20:19]), .wr_kind(reg_wdata[17:16]), .wr_addr(reg_wdata[ADDR_W-1:0]),
        .fin(fin), .fin_code(fin_code), .fin_data(fin_data),
        .go(go), .code(code), .lock(lock), .target(target), .kind(kind), .addr(addr),
        .rdata(acc_rdata)
    );

    cfgacc_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TGT_W(TGT_W), .PROT_LIMIT(PROT_LIMIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .target(target), .addr(addr),
        .lock_eff(lock_eff), .req_ready(req_ready), .done_valid(done_valid),
        .done_code(done_code), .done_data(done_data),
        .req_valid(req_valid), .req_kind(rq_kind), .req_target(req_target),
        .req_addr(req_addr), .fin(fin), .fin_code(fin_code), .fin_data(fin_data)
    );

    assign req_kind  = rq_kind;
    assign reg_rdata = {go, code, lock, 6'b0, target, 1'b0, kind, 4'b0, addr};

    for (genvar g = 0; g < NDEV; g++) begin : g_cs
        assign req_cs_n[g] = !(req_valid && req_target == TGT_W'(g));
    end

    // R3
    cs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones(~req_cs_n) == 1);

    // R1
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> &req_cs_n);

endmodule

// File: tb/sim_remote_cfg_access.sv
module sim_remote_cfg_access;

    localparam int CLK_P = 10;
    localparam int WD_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] acc_rd;
    logic        fatal = 1'b0;
    logic        rq_valid;
    logic        rq_ready = 1'b0;
    logic [1:0]  rq_kind;
    logic [1:0]  rq_tgt;
    logic [11:0] rq_addr;
    logic [3:0]  cs_n;
    logic        dn_valid = 1'b0;
    logic [2:0]  dn_code = '0;
    logic [31:0] dn_data = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    remote_cfg_access u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wdata(wdata),
        .reg_rdata(rdata), .acc_rdata(acc_rd), .link_fatal_err(fatal),
        .req_valid(rq_valid), .req_ready(rq_ready), .req_kind(rq_kind),
        .req_target(rq_tgt), .req_addr(rq_addr), .req_cs_n(cs_n),
        .done_valid(dn_valid), .done_code(dn_code), .done_data(dn_data)
    );

    function automatic logic [31:0] mk(input logic g, input logic [2:0] st, input logic lk,
                                       input logic [1:0] tg, input logic [1:0] kd,
                                       input logic [11:0] a);
        return {g, st, lk, 6'b0, tg, 1'b0, kd, 4'b0, a};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wdata = d;
        tick(1);
        wr_en = 1'b0;
        wdata = '0;
    endtask

    task automatic clear_code();
        wr(mk(0, 3'b111, 0, 2'd0, 2'd0, 12'h0));
    endtask

    task automatic finish_access(input logic [2:0] c, input logic [31:0] d);
        rq_ready = 1'b1;
        tick(1);
        rq_ready = 1'b0;
        dn_valid = 1'b1;
        dn_code  = c;
        dn_data  = d;
        tick(1);
        dn_valid = 1'b0;
        dn_code  = '0;
        dn_data  = '0;
    endtask

    task automatic test_reset();
        chk("R1", "control word", rdata, 32'h0);
        chk("R1", "read data", acc_rd, 32'h0);
        chk("R1", "req valid", {31'b0, rq_valid}, 32'h0);
        chk("R1", "chip selects", {28'b0, cs_n}, 32'hF);
    endtask

    task automatic test_fields();
        wr(32'h07E4_F000 | mk(0, 0, 0, 2'd2, 2'd1, 12'hABC));
        chk("R2", "fields and reserved zero", rdata, mk(0, 0, 0, 2'd2, 2'd1, 12'hABC));
    endtask

    task automatic test_read();
        wr(mk(1, 0, 0, 2'd1, 2'd0, 12'h123));
        tick(1);
        chk("R3", "req valid", {31'b0, rq_valid}, 32'h1);
        chk("R3", "payload", {16'b0, rq_kind, rq_tgt, rq_addr}, {16'b0, 2'd0, 2'd1, 12'h123});
        chk("R3", "chip select", {28'b0, cs_n}, 32'hD);
        tick(2);
        chk("R3", "held while stalled", {15'b0, rq_valid, rq_kind, rq_tgt, rq_addr},
            {15'b0, 1'b1, 2'd0, 2'd1, 12'h123});
        rq_ready = 1'b1;
        tick(1);
        rq_ready = 1'b0;
        chk("R3", "req dropped after accept", {31'b0, rq_valid}, 32'h0);
        chk("R4", "start still set in flight", {31'b0, rdata[31]}, 32'h1);
        dn_valid = 1'b1; dn_code = 3'd7; dn_data = 32'hA5A5_1234;
        tick(1);
        dn_valid = 1'b0;
        chk("R4", "start and code", {28'b0, rdata[31:28]}, 32'h7);
        chk("R4", "read data", acc_rd, 32'hA5A5_1234);
    endtask

    task automatic test_code_gate();
        wr(mk(1, 0, 0, 2'd0, 2'd0, 12'h0));
        tick(3);
        chk("R5", "no request with code set", {31'b0, rq_valid}, 32'h0);
        chk("R5", "start refused", {28'b0, rdata[31:28]}, 32'h7);
        wr(mk(0, 3'b010, 0, 2'd0, 2'd0, 12'h0));
        chk("R5", "partial clear", {29'b0, rdata[30:28]}, 32'h5);
        clear_code();
        chk("R5", "full clear", {29'b0, rdata[30:28]}, 32'h0);
    endtask

    task automatic test_stat_and_reset();
        wr(mk(1, 0, 0, 2'd2, 2'd2, 12'h5A5));
        tick(1);
        chk("R6", "status read addr", {20'b0, rq_addr}, 32'h0);
        chk("R6", "status read cs", {28'b0, cs_n}, 32'hB);
        finish_access(3'd7, 32'hDEAD_BEEF);
        chk("R6", "status data low half", acc_rd, 32'h0000_BEEF);
        clear_code();
        wr(mk(1, 0, 0, 2'd3, 2'd3, 12'hFFF));
        tick(1);
        chk("R6", "in-band reset addr", {20'b0, rq_addr}, 32'h0);
        chk("R6", "in-band reset cs", {28'b0, cs_n}, 32'h7);
        finish_access(3'd4, 32'h1234_5678);
        chk("R6", "in-band reset no data", acc_rd, 32'h0);
        chk("R4", "non-fatal code", {29'b0, rdata[30:28]}, 32'h4);
        clear_code();
    endtask

    task automatic test_lock();
        wr(mk(0, 0, 1, 2'd0, 2'd0, 12'h0));
        chk("R7", "lock set", {31'b0, rdata[27]}, 32'h1);
        wr(mk(0, 0, 0, 2'd0, 2'd0, 12'h0));
        chk("R7", "lock survives zero write", {31'b0, rdata[27]}, 32'h1);
        wr(mk(1, 0, 0, 2'd0, 2'd1, 12'h7FF));
        tick(1);
        chk("R8", "no request for locked write", {31'b0, rq_valid}, 32'h0);
        chk("R8", "start set before retire", {31'b0, rdata[31]}, 32'h1);
        tick(1);
        chk("R8", "retired with fatal code", {28'b0, rdata[31:28]}, 32'h3);
        chk("R8", "no request after retire", {31'b0, rq_valid}, 32'h0);
        clear_code();
        wr(mk(1, 0, 0, 2'd0, 2'd1, 12'h800));
        tick(1);
        chk("R9", "write at 0x800 issued", {19'b0, rq_valid, rq_addr}, {19'b0, 1'b1, 12'h800});
        finish_access(3'd7, 32'h0);
        clear_code();
        wr(mk(1, 0, 0, 2'd0, 2'd0, 12'h010));
        tick(1);
        chk("R9", "read in range issued", {31'b0, rq_valid}, 32'h1);
        finish_access(3'd7, 32'h0000_00AA);
        chk("R9", "locked-range read data", acc_rd, 32'h0000_00AA);
        clear_code();
    endtask

    task automatic test_fatal();
        fatal = 1'b1;
        wr(mk(1, 0, 0, 2'd1, 2'd1, 12'h010));
        tick(1);
        chk("R10", "lock suspended", {19'b0, rq_valid, rq_addr}, {19'b0, 1'b1, 12'h010});
        finish_access(3'd7, 32'h0);
        chk("R10", "completed ok", {28'b0, rdata[31:28]}, 32'h7);
        clear_code();
        fatal = 1'b0;
    endtask

    task automatic test_busy_hold();
        wr(mk(1, 0, 0, 2'd0, 2'd0, 12'h111));
        tick(1);
        rq_ready = 1'b1;
        tick(1);
        rq_ready = 1'b0;
        wr(mk(0, 3'b111, 0, 2'd3, 2'd1, 12'hFFF));
        chk("R11", "fields held in flight", {11'b0, rdata[20:0]}, {11'b0, 21'h00_0111});
        chk("R11", "start and code held", {28'b0, rdata[31:28]}, 32'h8);
        finish_access(3'd7, 32'h0000_0077);
        chk("R11", "read data after hold", acc_rd, 32'h0000_0077);
        clear_code();
    endtask

    task automatic test_stray_done();
        dn_valid = 1'b1; dn_code = 3'd4; dn_data = 32'hFFFF_FFFF;
        tick(1);
        dn_valid = 1'b0;
        tick(1);
        chk("R12", "code untouched", {28'b0, rdata[31:28]}, 32'h0);
        chk("R12", "read data untouched", acc_rd, 32'h0000_0077);
    endtask

    task automatic test_plat_reset();
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        chk("R7", "lock cleared by reset", rdata, 32'h0);
        chk("R1", "read data after reset", acc_rd, 32'h0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        test_reset();
        test_fields();
        test_read();
        test_code_gate();
        test_stat_and_reset();
        test_lock();
        test_fatal();
        test_busy_hold();
        test_stray_done();
        test_plat_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule